// File: doc/BRIEF.md
# Three-Wire Compass Sensor Controller

This block is the master side of a serial magnetometer that is wired with three lines: an active-low frame enable, a serial clock, and one data line that both ends share. A single start pulse makes the controller run a full measurement. It sends a reset command and then a measure command. After that it polls the sensor with a report command until the sensor either says the sample is finished or reports a fault. Every command is a 4-bit code, shifted out most significant bit first, inside its own enable-low frame.

Each report frame has the same layout. The controller sends the 4-bit command and then lets go of the data line. It clocks in 26 bits: a 4-bit status code followed by two 11-bit two's-complement field readings, first the X axis and then the Y axis. The sensor sends all 26 bits even when the sample is not yet finished, so the controller reads the whole frame every time and decides what to do from the status. A finished sample updates both signed outputs together with a one-cycle strobe. A fault, or too many unfinished polls, raises the error flag instead.

The serial clock rate is a parameter. The controller derives it from the system clock frequency, with a half period of CLK_HZ/(2*SCLK_HZ) system cycles.

Top module: `m3w_compass_ctrl`

## Requirements
- R1: While and after reset the outputs are: en_n_o=1, sclk_o=0, sdio_oe_o=0, busy_o=0, valid_o=0, error_o=0, and x_o=y_o=0.
- R2: A start pulse produces three enable-low frames, each separated by enable high. They carry the command codes 4'b0000 (reset), 4'b1000 (measure) and 4'b1100 (report), each shifted out MSB first on rising sclk_o. The reset and measure frames have exactly 4 clock pulses.
- R3: The controller drives the data line (sdio_oe_o=1) only during the command bits of a frame. It never drives it while en_n_o is high or during the read phase.
- R4: A report frame has 30 clock pulses: 4 command bits and then 26 read bits, each sampled on rising sclk_o. The read bits are the status (bits 25..22), then X (bits 21..11), then Y (bits 10..0), each field MSB first.
- R5: A status of 4'b1100 ends the run. valid_o pulses for exactly one cycle, and x_o and y_o take the new readings in that same cycle. At all other times x_o and y_o hold their values.
- R6: Each axis reading is 11-bit two's complement and is sign-extended to OUT_W bits (for example 11'h7FF gives -1, and 11'h400 gives -1024).
- R7: A status whose two low bits are 2'b11 raises error_o with no valid_o pulse, and the outputs keep their old values. Any other status that is neither 4'b1100 nor has upper bits 2'b00 is treated the same way.
- R8: A status with upper bits 2'b00 and low bits other than 2'b11 is "pending". The controller issues another report frame, without repeating the reset or measure frames, up to a total of poll_limit_i report frames (a limit of 0 counts as 1). If the last allowed frame is still pending, error_o rises.
- R9: busy_o rises in the cycle after an accepted start and falls in the same cycle that valid_o pulses or error_o rises. A start while busy is ignored. error_o stays high until the next accepted start clears it.
- R10: sclk_o idles low whenever en_n_o is high. Every high or low phase of sclk_o lasts a whole multiple of HALF_DIV = CLK_HZ/(2*SCLK_HZ) system cycles, and the high phase lasts exactly HALF_DIV.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to take a measurement |
| poll_limit_i | input | POLL_W | Maximum number of report frames per run, latched at start |
| busy_o | output | 1 | A measurement run is in progress |
| valid_o | output | 1 | One-cycle strobe: x_o and y_o were just updated |
| error_o | output | 1 | Last run ended on a fault status or on the poll limit |
| x_o | output | OUT_W | Sign-extended X field reading |
| y_o | output | OUT_W | Sign-extended Y field reading |
| en_n_o | output | 1 | Active-low sensor frame enable |
| sclk_o | output | 1 | Serial clock to the sensor |
| sdio_o | output | 1 | Data value driven onto the shared line |
| sdio_oe_o | output | 1 | Output enable for the shared data line |
| sdio_i | input | 1 | Data value read back from the shared line |

## Verification
The checker watches the line discipline on every cycle. It checks that the data line is never driven and the clock never toggles outside a frame, and that each clock phase honours the divider. It checks that the valid strobe lasts one cycle, never coincides with the error flag, and that the readings change only with it. It also checks that busy falls only when a run ends. The command order and the bit position of each field can only be shown by the bench's sensor model, as can the choice between finishing, re-polling and faulting on each status code, the poll limit count and the sign extension of the decoded values.

// File: rtl/m3w_pkg.sv
package m3w_pkg;

    localparam int unsigned CMD_W   = 4;
    localparam int unsigned STAT_W  = 4;
    localparam int unsigned AXIS_W  = 11;
    localparam int unsigned RD_W    = STAT_W + 2 * AXIS_W;

    localparam logic [CMD_W-1:0]  CMD_RESET   = 4'b0000;
    localparam logic [CMD_W-1:0]  CMD_MEASURE = 4'b1000;
    localparam logic [CMD_W-1:0]  CMD_REPORT  = 4'b1100;
    localparam logic [STAT_W-1:0] STAT_OK     = 4'b1100;

    typedef enum logic [1:0] {
        FR_RESET,
        FR_MEASURE,
        FR_REPORT
    } frame_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_OPEN,
        SQ_XFER,
        SQ_CLOSE,
        SQ_EVAL
    } seq_state_e;

    typedef enum logic [1:0] {
        ST_DONE,
        ST_PENDING,
        ST_FAULT
    } stat_kind_e;

    typedef struct packed {
        logic [STAT_W-1:0] status;
        logic [AXIS_W-1:0] x;
        logic [AXIS_W-1:0] y;
    } report_t;

    function automatic int unsigned half_div(input int unsigned clk_hz,
                                             input int unsigned sclk_hz);
        int unsigned d;
        d = clk_hz / (2 * sclk_hz);
        return (d < 1) ? 1 : d;
    endfunction

    function automatic logic [CMD_W-1:0] frame_cmd(input frame_e f);
        case (f)
            FR_RESET:   return CMD_RESET;
            FR_MEASURE: return CMD_MEASURE;
            default:    return CMD_REPORT;
        endcase
    endfunction

    // Fault on low bits 11 takes priority over every other code.
    function automatic stat_kind_e classify(input logic [STAT_W-1:0] s);
        if (s[1:0] == 2'b11)      return ST_FAULT;
        else if (s == STAT_OK)    return ST_DONE;
        else if (s[3:2] == 2'b00) return ST_PENDING;
        else                      return ST_FAULT;
    endfunction

endpackage

// File: rtl/m3w_tick_gen.sv
module m3w_tick_gen #(
    parameter int unsigned HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int unsigned CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_DIV - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)      cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt == LAST);
endmodule

// File: rtl/m3w_bitio.sv
module m3w_bitio
    import m3w_pkg::*;
#(
    parameter int unsigned CW = CMD_W,
    parameter int unsigned RW = RD_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          go,
    input  logic [CW-1:0] cmd,
    input  logic          rd_en,
    input  logic          sdio_i,
    output logic          sclk_o,
    output logic          sdio_o,
    output logic          sdio_oe_o,
    output logic          done_o,
    output logic [RW-1:0] rx_o
);
    localparam int unsigned TOT   = CW + RW;
    localparam int unsigned IDX_W = $clog2(TOT + 1);
    localparam logic [IDX_W-1:0] WR_END = IDX_W'(CW);

    logic             active;
    logic             hi;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] last_idx;
    logic [CW-1:0]    cmd_sr;
    logic [RW-1:0]    rx_sr;
    logic             in_write;

    assign in_write = active && (idx < WR_END);

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            hi       <= 1'b0;
            idx      <= '0;
            last_idx <= '0;
            cmd_sr   <= '0;
            rx_sr    <= '0;
            done_o   <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (go) begin
                active   <= 1'b1;
                hi       <= 1'b0;
                idx      <= '0;
                last_idx <= rd_en ? IDX_W'(TOT - 1) : IDX_W'(CW - 1);
                cmd_sr   <= cmd;
            end else if (active && tick) begin
                if (!hi) begin
                    hi <= 1'b1;
                    if (!in_write) rx_sr <= {rx_sr[RW-2:0], sdio_i};
                end else begin
                    hi <= 1'b0;
                    if (in_write) cmd_sr <= {cmd_sr[CW-2:0], 1'b0};
                    if (idx == last_idx) begin
                        active <= 1'b0;
                        done_o <= 1'b1;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
            end
        end
    end

    assign sclk_o    = hi;
    assign sdio_oe_o = in_write;
    assign sdio_o    = in_write ? cmd_sr[CW-1] : 1'b0;
    assign rx_o      = rx_sr;
endmodule

// File: rtl/m3w_unpack.sv
module m3w_unpack
    import m3w_pkg::*;
#(
    parameter int unsigned OUT_W = 16
) (
    input  logic [RD_W-1:0]  rx,
    output stat_kind_e       kind,
    output logic [OUT_W-1:0] x_ext,
    output logic [OUT_W-1:0] y_ext
);
    report_t rep;
    assign rep  = report_t'(rx);
    assign kind = classify(rep.status);

    generate
        if (OUT_W > AXIS_W) begin : g_extend
            assign x_ext = {{(OUT_W - AXIS_W){rep.x[AXIS_W-1]}}, rep.x};
            assign y_ext = {{(OUT_W - AXIS_W){rep.y[AXIS_W-1]}}, rep.y};
        end else begin : g_trunc
            assign x_ext = rep.x[OUT_W-1:0];
            assign y_ext = rep.y[OUT_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/m3w_compass_ctrl.sv
module m3w_compass_ctrl
    import m3w_pkg::*;
#(
    parameter int unsigned CLK_HZ  = 125_000_000,
    parameter int unsigned SCLK_HZ = 400_000,
    parameter int unsigned OUT_W   = 16,
    parameter int unsigned POLL_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [POLL_W-1:0] poll_limit_i,
    output logic              busy_o,
    output logic              valid_o,
    output logic              error_o,
    output logic [OUT_W-1:0]  x_o,
    output logic [OUT_W-1:0]  y_o,
    output logic              en_n_o,
    output logic              sclk_o,
    output logic              sdio_o,
    output logic              sdio_oe_o,
    input  logic              sdio_i
);
    localparam int unsigned HALF_DIV = half_div(CLK_HZ, SCLK_HZ);

    seq_state_e        state;
    frame_e            frame;
    logic              go;
    logic              tick;
    logic              done;
    logic [RD_W-1:0]   rx;
    stat_kind_e        kind;
    logic [OUT_W-1:0]  x_new, y_new;
    logic [POLL_W-1:0] limit_q;
    logic [POLL_W:0]   polls_q;
    logic [POLL_W:0]   polls_next;
    logic [POLL_W:0]   limit_eff;

    m3w_tick_gen #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (busy_o),
        .tick (tick)
    );

    m3w_bitio #(.CW(CMD_W), .RW(RD_W)) u_bitio (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .go        (go),
        .cmd       (frame_cmd(frame)),
        .rd_en     (frame == FR_REPORT),
        .sdio_i    (sdio_i),
        .sclk_o    (sclk_o),
        .sdio_o    (sdio_o),
        .sdio_oe_o (sdio_oe_o),
        .done_o    (done),
        .rx_o      (rx)
    );

    m3w_unpack #(.OUT_W(OUT_W)) u_unpack (
        .rx    (rx),
        .kind  (kind),
        .x_ext (x_new),
        .y_ext (y_new)
    );

    always_comb begin
        polls_next = polls_q + 1'b1;
        limit_eff  = (limit_q == '0) ? (POLL_W+1)'(1) : {1'b0, limit_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SQ_IDLE;
            frame   <= FR_RESET;
            go      <= 1'b0;
            en_n_o  <= 1'b1;
            busy_o  <= 1'b0;
            valid_o <= 1'b0;
            error_o <= 1'b0;
            x_o     <= '0;
            y_o     <= '0;
            limit_q <= '0;
            polls_q <= '0;
        end else begin
            go      <= 1'b0;
            valid_o <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (start_i) begin
                        busy_o  <= 1'b1;
                        error_o <= 1'b0;
                        frame   <= FR_RESET;
                        polls_q <= '0;
                        limit_q <= poll_limit_i;
                        en_n_o  <= 1'b0;
                        state   <= SQ_OPEN;
                    end
                end
                SQ_OPEN: begin
                    if (tick) begin
                        go    <= 1'b1;
                        state <= SQ_XFER;
                    end
                end
                SQ_XFER: begin
                    if (done) begin
                        en_n_o <= 1'b1;
                        state  <= SQ_CLOSE;
                    end
                end
                SQ_CLOSE: begin
                    if (tick) begin
                        case (frame)
                            FR_RESET: begin
                                frame  <= FR_MEASURE;
                                en_n_o <= 1'b0;
                                state  <= SQ_OPEN;
                            end
                            FR_MEASURE: begin
                                frame  <= FR_REPORT;
                                en_n_o <= 1'b0;
                                state  <= SQ_OPEN;
                            end
                            default: state <= SQ_EVAL;
                        endcase
                    end
                end
                SQ_EVAL: begin
                    case (kind)
                        ST_DONE: begin
                            x_o     <= x_new;
                            y_o     <= y_new;
                            valid_o <= 1'b1;
                            busy_o  <= 1'b0;
                            state   <= SQ_IDLE;
                        end
                        ST_PENDING: begin
                            if (polls_next >= limit_eff) begin
                                error_o <= 1'b1;
                                busy_o  <= 1'b0;
                                state   <= SQ_IDLE;
                            end else begin
                                polls_q <= polls_next;
                                en_n_o  <= 1'b0;
                                state   <= SQ_OPEN;
                            end
                        end
                        default: begin
                            error_o <= 1'b1;
                            busy_o  <= 1'b0;
                            state   <= SQ_IDLE;
                        end
                    endcase
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/m3w_compass_ctrl_chk.sv
module m3w_compass_ctrl_chk #(
    parameter int unsigned OUT_W    = 16,
    parameter int unsigned HALF_DIV = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             busy_o,
    input logic             valid_o,
    input logic             error_o,
    input logic [OUT_W-1:0] x_o,
    input logic [OUT_W-1:0] y_o,
    input logic             en_n_o,
    input logic             sclk_o,
    input logic             sdio_oe_o
);
    logic        sclk_q;
    int unsigned hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            hold   <= HALF_DIV;
        end else begin
            sclk_q <= sclk_o;
            if (sclk_o != sclk_q)   hold <= 1;
            else if (hold < 32'hFFFF_FFF0) hold <= hold + 1;
        end
    end

    assert_line_released_R3: assert property (@(posedge clk) disable iff (rst)
        en_n_o |-> !sdio_oe_o);

    assert_sclk_idle_R10: assert property (@(posedge clk) disable iff (rst)
        en_n_o |-> !sclk_o);

    assert_sclk_phase_R10: assert property (@(posedge clk) disable iff (rst)
        (sclk_o != sclk_q) |-> (hold >= HALF_DIV));

    assert_valid_single_R5: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    assert_hold_outputs_R5: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> ($stable(x_o) && $stable(y_o)));

    assert_no_valid_on_error_R7: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> !error_o);

    assert_busy_end_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> (valid_o || error_o));

    assert_error_ends_run_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(error_o) |-> $fell(busy_o));
endmodule

bind m3w_compass_ctrl m3w_compass_ctrl_chk #(
    .OUT_W    (OUT_W),
    .HALF_DIV (HALF_DIV)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy_o    (busy_o),
    .valid_o   (valid_o),
    .error_o   (error_o),
    .x_o       (x_o),
    .y_o       (y_o),
    .en_n_o    (en_n_o),
    .sclk_o    (sclk_o),
    .sdio_oe_o (sdio_oe_o)
);

// File: tb/m3w_compass_ctrl_tb.sv
module m3w_compass_ctrl_tb;
    localparam int unsigned CLK_HZ  = 125_000_000;
    localparam int unsigned SCLK_HZ = 12_500_000;
    localparam int unsigned HALF    = 5;
    localparam int unsigned OUT_W   = 16;
    localparam int unsigned POLL_W  = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start_i = 1'b0;
    logic [POLL_W-1:0] poll_limit_i = 8'd4;
    logic              busy_o, valid_o, error_o;
    logic [OUT_W-1:0]  x_o, y_o;
    logic              en_n_o, sclk_o, sdio_o, sdio_oe_o;
    logic              sdio_i = 1'b0;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    m3w_compass_ctrl #(
        .CLK_HZ(CLK_HZ), .SCLK_HZ(SCLK_HZ), .OUT_W(OUT_W), .POLL_W(POLL_W)
    ) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .poll_limit_i(poll_limit_i),
        .busy_o(busy_o), .valid_o(valid_o), .error_o(error_o),
        .x_o(x_o), .y_o(y_o), .en_n_o(en_n_o), .sclk_o(sclk_o),
        .sdio_o(sdio_o), .sdio_oe_o(sdio_oe_o), .sdio_i(sdio_i)
    );

    // ---------------- sensor model ----------------
    logic [25:0] resp_tab [0:7];
    logic [3:0]  cmd_log  [0:15];
    int          bits_log [0:15];
    int          frame_cnt, rep_idx, drv_err, bitn, valid_cnt, idle_viol;
    int          hi_run, last_hi, hi_bad;
    logic [3:0]  cmd;

    function automatic logic [25:0] cur_resp();
        return resp_tab[(rep_idx > 7) ? 7 : rep_idx];
    endfunction

    initial begin
        frame_cnt = 0; rep_idx = 0; drv_err = 0; bitn = 0; cmd = 4'b0;
        valid_cnt = 0; idle_viol = 0; hi_run = 0; last_hi = 0; hi_bad = 0;
    end

    always @(negedge en_n_o) begin
        bitn = 0;
        cmd  = 4'b0;
    end

    always @(posedge sclk_o) begin
        if (!en_n_o) begin
            if (bitn < 4) begin
                if (!sdio_oe_o) drv_err++;
                cmd = {cmd[2:0], sdio_o};
            end else if (sdio_oe_o) begin
                drv_err++;
            end
            bitn++;
        end
    end

    always @(negedge sclk_o) begin
        if (!en_n_o && bitn >= 4 && bitn < 30 && cmd == 4'b1100)
            sdio_i = cur_resp()[29 - bitn];
    end

    always @(posedge en_n_o) begin
        if (bitn > 0) begin
            if (frame_cnt < 16) begin
                cmd_log[frame_cnt]  = cmd;
                bits_log[frame_cnt] = bitn;
            end
            if (cmd == 4'b1100) rep_idx++;
            frame_cnt++;
        end
        bitn   = 0;
        sdio_i = 1'b0;
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (valid_o) valid_cnt++;
            if (en_n_o && (sclk_o || sdio_oe_o)) idle_viol++;
            if (sclk_o) hi_run++;
            else if (hi_run != 0) begin
                last_hi = hi_run;
                if (hi_run != HALF) hi_bad++;
                hi_run = 0;
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [OUT_W-1:0] sx(input logic [10:0] v);
        return {{(OUT_W-11){v[10]}}, v};
    endfunction

    task automatic clear_model();
        frame_cnt = 0; rep_idx = 0; drv_err = 0; valid_cnt = 0;
        idle_viol = 0; hi_bad = 0;
    endtask

    task automatic run_txn(input logic [POLL_W-1:0] lim, input bit poke_start);
        int guard;
        clear_model();
        @(negedge clk);
        poll_limit_i = lim;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R9", "busy after start", busy_o, 1);
        guard = 0;
        while (busy_o && guard < 40000) begin
            @(negedge clk);
            guard++;
            if (poke_start && (guard % 37) == 0) start_i = 1'b1;
            else start_i = 1'b0;
        end
        start_i = 1'b0;
        chk("R9", "run ended", busy_o, 0);
        repeat (4) @(negedge clk);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk("R1", "en_n", en_n_o, 1);
        chk("R1", "sclk", sclk_o, 0);
        chk("R1", "oe", sdio_oe_o, 0);
        chk("R1", "busy", busy_o, 0);
        chk("R1", "valid", valid_o, 0);
        chk("R1", "error", error_o, 0);
        chk("R1", "x", x_o, 0);
        chk("R1", "y", y_o, 0);
    endtask

    task automatic t_basic();
        resp_tab[0] = {4'b1100, 11'h000, 11'h7FA};
        run_txn(8'd4, 1'b0);
        chk("R2", "frames", frame_cnt, 3);
        chk("R2", "cmd reset", cmd_log[0], 4'b0000);
        chk("R2", "cmd measure", cmd_log[1], 4'b1000);
        chk("R2", "cmd report", cmd_log[2], 4'b1100);
        chk("R2", "reset bits", bits_log[0], 4);
        chk("R2", "measure bits", bits_log[1], 4);
        chk("R4", "report bits", bits_log[2], 30);
        chk("R3", "driver conflicts", drv_err, 0);
        chk("R3", "drive outside frame", idle_viol, 0);
        chk("R5", "valid pulses", valid_cnt, 1);
        chk("R7", "no error", error_o, 0);
        chk("R4", "x", x_o, 16'h0000);
        chk("R6", "y -6", y_o, 16'hFFFA);
        chk("R10", "sclk high length", last_hi, HALF);
        chk("R10", "bad high phases", hi_bad, 0);
    endtask

    task automatic t_extremes();
        resp_tab[0] = {4'b1100, 11'h400, 11'h3FF};
        run_txn(8'd4, 1'b0);
        chk("R6", "x -1024", x_o, sx(11'h400));
        chk("R6", "y +1023", y_o, 16'h03FF);
        resp_tab[0] = {4'b1100, 11'h7FF, 11'h7F5};
        run_txn(8'd4, 1'b0);
        chk("R6", "x -1", x_o, 16'hFFFF);
        chk("R4", "y -11", y_o, 16'hFFF5);
    endtask

    task automatic t_pending();
        resp_tab[0] = {4'b0000, 11'h123, 11'h456};
        resp_tab[1] = {4'b0001, 11'h155, 11'h2AA};
        resp_tab[2] = {4'b1100, 11'h7FF, 11'h7ED};
        run_txn(8'd4, 1'b0);
        chk("R8", "frames", frame_cnt, 5);
        chk("R8", "repoll cmd a", cmd_log[3], 4'b1100);
        chk("R8", "repoll cmd b", cmd_log[4], 4'b1100);
        chk("R8", "repoll bits", bits_log[4], 30);
        chk("R5", "valid pulses", valid_cnt, 1);
        chk("R6", "x -1", x_o, 16'hFFFF);
        chk("R6", "y -19", y_o, 16'hFFED);
        chk("R8", "no error", error_o, 0);
    endtask

    task automatic t_fault(input logic [3:0] st, input string tag);
        logic [OUT_W-1:0] px, py;
        px = x_o; py = y_o;
        resp_tab[0] = {st, 11'h0AA, 11'h055};
        run_txn(8'd4, 1'b0);
        chk("R7", {tag, " error"}, error_o, 1);
        chk("R7", {tag, " no valid"}, valid_cnt, 0);
        chk("R7", {tag, " x held"}, x_o, px);
        chk("R7", {tag, " y held"}, y_o, py);
        chk("R7", {tag, " frames"}, frame_cnt, 3);
    endtask

    task automatic t_limit();
        for (int i = 0; i < 8; i++) resp_tab[i] = {4'b0010, 11'h001, 11'h002};
        run_txn(8'd2, 1'b0);
        chk("R8", "limit 2 frames", frame_cnt, 4);
        chk("R8", "limit 2 error", error_o, 1);
        chk("R8", "limit 2 no valid", valid_cnt, 0);
        run_txn(8'd0, 1'b0);
        chk("R8", "limit 0 frames", frame_cnt, 3);
        chk("R8", "limit 0 error", error_o, 1);
    endtask

    task automatic t_recover_and_ignore();
        resp_tab[0] = {4'b1100, 11'h010, 11'h7F0};
        run_txn(8'd4, 1'b1);
        chk("R9", "error cleared", error_o, 0);
        chk("R9", "extra starts ignored frames", frame_cnt, 3);
        chk("R9", "extra starts one valid", valid_cnt, 1);
        chk("R5", "x", x_o, 16'h0010);
        chk("R5", "y", y_o, 16'hFFF0);
        repeat (40) @(negedge clk);
        chk("R9", "no restart", frame_cnt, 3);
        chk("R9", "idle", busy_o, 0);
    endtask

    // ---------------- main ----------------
    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        t_basic();
        t_extremes();
        t_pending();
        t_fault(4'b0011, "st0011");
        t_fault(4'b1111, "st1111");
        t_fault(4'b0100, "st0100");
        t_limit();
        t_recover_and_ignore();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(8 * 190000);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule